// File: doc/BRIEF.md
# Execute Group Redirect Selector

This block sits at the end of the execute stage of an out-of-order core. Each cycle it takes the group of up to issue-width instructions handed over by the issue logic. It works out which of them are forwarded toward commit and how many functional units the group occupies. It then picks at most one fetch redirect for the group. A redirect comes from a mispredicted branch, or from a memory-order violation that the load/store unit raises for the group.

The chosen redirect becomes a registered squash packet toward commit, valid for one cycle. A branch packet carries the recomputed taken direction. A memory packet carries only the restart point. Two counters record how many honoured branch redirects had been predicted taken, and how many memory-order redirects were raised. Actual ALU execution happens elsewhere.

Top module: `exec_redirect_sel`

## Requirements
- R1: While `rst_n` is low at a clock edge, every output register (squash packet, forward mask, unit count and both counters) is cleared to zero.
- R2: Slots are scanned from slot 0 upward, and scanning stops at the first slot whose valid bit is low. Bit i of `fwd_mask` is set when slot i was scanned and forwarded, so the mask is always a run of ones starting at bit 0.
- R3: `fu_used` equals the number of scanned slots that are not squashed. When that count reaches `EXEC_W`, scanning stops before the next slot, even if the next slot is squashed.
- R4: A squashed slot is forwarded and still counts toward the scan, but it adds nothing to `fu_used` and never raises a redirect.
- R5: Only the lowest-numbered scanned, non-squashed slot that qualifies for a redirect is honoured. Later mispredicts or violations in the same group are ignored.
- R6: In one slot, a mispredict takes priority over a memory violation.
- R7: The group violation flag makes a slot qualify only when that slot is a scanned, non-squashed memory reference.
- R8: A branch redirect sets `sq_valid` and `sq_mispred`, and carries that slot's sequence number, PC and next-PC.
- R9: For a branch redirect, `sq_taken` is 1 exactly when next-PC differs from PC + 4.
- R10: A memory-order redirect sets `sq_valid` and carries that slot's sequence number and next-PC. In that packet `sq_mispred`, `sq_taken` and `sq_pc` are 0.
- R11: `cnt_taken_wrong` increments once for each honoured branch redirect whose slot had predicted-taken set. `cnt_mem_order` increments once for each honoured memory-order redirect.
- R12: All outputs are registered. The packet, mask and count for a group appear at the first clock edge after the group is presented. `sq_valid` is high for that one cycle only, unless the next group also redirects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slot_valid | input | ISSUE_W | Slot holds an instruction |
| slot_squashed | input | ISSUE_W | Slot instruction already squashed |
| slot_mispred | input | ISSUE_W | Slot branch resolved as mispredicted |
| slot_pred_taken | input | ISSUE_W | Slot branch had been predicted taken |
| slot_memref | input | ISSUE_W | Slot is a load or store |
| slot_pc | input | ISSUE_W*PC_W | Per-slot PC, slot i at bits i*PC_W |
| slot_npc | input | ISSUE_W*PC_W | Per-slot resolved next-PC |
| slot_seq | input | ISSUE_W*SEQ_W | Per-slot sequence number |
| grp_violation | input | 1 | Load/store unit reports an ordering violation for this group |
| sq_valid | output | 1 | Squash packet valid |
| sq_mispred | output | 1 | Packet is a branch mispredict |
| sq_taken | output | 1 | Recomputed branch direction |
| sq_seq | output | SEQ_W | Sequence number of the redirecting slot |
| sq_pc | output | PC_W | PC of the mispredicted branch |
| sq_npc | output | PC_W | Restart PC |
| fwd_mask | output | ISSUE_W | Slots forwarded toward commit |
| fu_used | output | $clog2(EXEC_W+1) | Functional units occupied by the group |
| cnt_taken_wrong | output | CNT_W | Predicted-taken mispredict count |
| cnt_mem_order | output | CNT_W | Memory-order redirect count |

## Verification
Every result for a group is due exactly one clock edge after the group is driven. The bench drives a group on the falling edge. It works out the expected packet, mask, unit count and counter totals from that group. It then compares all outputs at the next falling edge, half a period after the capturing edge, before the next group changes them. Directed groups cover gaps, squashed slots, the unit limit (the bench uses a unit limit below the issue width), priority and the taken bit. A long run of random groups follows under the same per-cycle comparison.

// File: rtl/erp_pkg.sv
// Package: shared types for the execute group redirect selector.
// Assumes nothing beyond IEEE 1800-2017.
package erp_pkg;
    // Cause of the redirect chosen for a group.
    typedef enum logic [1:0] {
        RD_NONE   = 2'd0,
        RD_BRANCH = 2'd1,
        RD_MEMORD = 2'd2
    } redir_kind_e;

    // Fixed instruction size used to derive the sequential PC.
    localparam int unsigned INSN_BYTES = 4;
endpackage

// File: rtl/erp_slot_scan.sv
// Module: scans the issue group in slot order and decides which slots are
// forwarded and which occupy a functional unit.
// Assumes: IW >= 1, EW >= 1; purely combinational.
module erp_slot_scan #(
    parameter int IW = 4,
    parameter int EW = 4,
    localparam int FW = $clog2(EW + 1)
) (
    input  logic [IW-1:0] valid,
    input  logic [IW-1:0] squashed,
    output logic [IW-1:0] fwd_mask,
    output logic [IW-1:0] exec_mask,
    output logic [FW-1:0] fu_count
);
    // Walk the slots; stop at an empty slot or a full set of units.
    always_comb begin
        logic stop;
        logic [FW-1:0] used;
        stop      = 1'b0;
        used      = '0;
        fwd_mask  = '0;
        exec_mask = '0;
        for (int i = 0; i < IW; i++) begin
            if (!valid[i] || used >= FW'(EW)) stop = 1'b1;
            if (!stop) begin
                fwd_mask[i] = 1'b1;
                if (!squashed[i]) begin
                    exec_mask[i] = 1'b1;
                    used = used + FW'(1);
                end
            end
        end
        fu_count = used;
    end
endmodule

// File: rtl/erp_redirect_pick.sv
// Module: picks the first redirect among executed slots; a mispredict is
// tested before a violation within each slot.
// Assumes: IW >= 2; exec_mask marks scanned, non-squashed slots.
module erp_redirect_pick
    import erp_pkg::*;
#(
    parameter int IW = 4,
    localparam int XW = $clog2(IW)
) (
    input  logic [IW-1:0] exec_mask,
    input  logic [IW-1:0] mispred,
    input  logic [IW-1:0] memref,
    input  logic          violation,
    output redir_kind_e   kind,
    output logic [XW-1:0] sel
);
    // First qualifying slot wins; later ones are ignored.
    always_comb begin
        kind = RD_NONE;
        sel  = '0;
        for (int i = 0; i < IW; i++) begin
            if (kind == RD_NONE && exec_mask[i]) begin
                if (mispred[i]) begin
                    kind = RD_BRANCH;
                    sel  = XW'(i);
                end else if (violation && memref[i]) begin
                    kind = RD_MEMORD;
                    sel  = XW'(i);
                end
            end
        end
    end
endmodule

// File: rtl/erp_event_counter.sv
// Module: wrapping event counter with synchronous active-low clear.
// Assumes: one increment per cycle at most.
module erp_event_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] count
);
    // Count one per cycle while inc is high.
    always_ff @(posedge clk) begin
        if (!rst_n)   count <= '0;
        else if (inc) count <= count + W'(1);
    end
endmodule

// File: rtl/exec_redirect_sel.sv
// Module: execute group redirect selector. Scans an issue group, counts
// functional-unit usage, selects at most one redirect and registers a
// one-cycle squash packet toward commit, plus two event counters.
// Assumes: ISSUE_W >= 2, fields packed slot 0 in the low bits.
module exec_redirect_sel
    import erp_pkg::*;
#(
    parameter int ISSUE_W = 4,
    parameter int EXEC_W  = 4,
    parameter int PC_W    = 32,
    parameter int SEQ_W   = 16,
    parameter int CNT_W   = 16,
    localparam int FW     = $clog2(EXEC_W + 1),
    localparam int XW     = $clog2(ISSUE_W)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ISSUE_W-1:0]       slot_valid,
    input  logic [ISSUE_W-1:0]       slot_squashed,
    input  logic [ISSUE_W-1:0]       slot_mispred,
    input  logic [ISSUE_W-1:0]       slot_pred_taken,
    input  logic [ISSUE_W-1:0]       slot_memref,
    input  logic [ISSUE_W*PC_W-1:0]  slot_pc,
    input  logic [ISSUE_W*PC_W-1:0]  slot_npc,
    input  logic [ISSUE_W*SEQ_W-1:0] slot_seq,
    input  logic                     grp_violation,
    output logic                     sq_valid,
    output logic                     sq_mispred,
    output logic                     sq_taken,
    output logic [SEQ_W-1:0]         sq_seq,
    output logic [PC_W-1:0]          sq_pc,
    output logic [PC_W-1:0]          sq_npc,
    output logic [ISSUE_W-1:0]       fwd_mask,
    output logic [FW-1:0]            fu_used,
    output logic [CNT_W-1:0]         cnt_taken_wrong,
    output logic [CNT_W-1:0]         cnt_mem_order
);
    logic [ISSUE_W-1:0] fwd_c, exec_c;
    logic [FW-1:0]      fu_c;
    redir_kind_e        kind_c;
    logic [XW-1:0]      sel_c;
    logic [PC_W-1:0]    pc_s, npc_s;
    logic [SEQ_W-1:0]   seq_s;
    logic               taken_c;

    erp_slot_scan #(.IW(ISSUE_W), .EW(EXEC_W)) u_scan (
        .valid(slot_valid), .squashed(slot_squashed),
        .fwd_mask(fwd_c), .exec_mask(exec_c), .fu_count(fu_c)
    );

    erp_redirect_pick #(.IW(ISSUE_W)) u_pick (
        .exec_mask(exec_c), .mispred(slot_mispred), .memref(slot_memref),
        .violation(grp_violation), .kind(kind_c), .sel(sel_c)
    );

    // Select the fields of the redirecting slot and recompute direction.
    always_comb begin
        pc_s    = slot_pc[sel_c*PC_W +: PC_W];
        npc_s   = slot_npc[sel_c*PC_W +: PC_W];
        seq_s   = slot_seq[sel_c*SEQ_W +: SEQ_W];
        taken_c = (npc_s != pc_s + PC_W'(INSN_BYTES));
    end

    // Register the squash packet and group summary for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sq_valid   <= 1'b0;
            sq_mispred <= 1'b0;
            sq_taken   <= 1'b0;
            sq_seq     <= '0;
            sq_pc      <= '0;
            sq_npc     <= '0;
            fwd_mask   <= '0;
            fu_used    <= '0;
        end else begin
            sq_valid   <= (kind_c != RD_NONE);
            sq_mispred <= (kind_c == RD_BRANCH);
            sq_taken   <= (kind_c == RD_BRANCH) && taken_c;
            sq_seq     <= (kind_c != RD_NONE) ? seq_s : '0;
            sq_pc      <= (kind_c == RD_BRANCH) ? pc_s : '0;
            sq_npc     <= (kind_c != RD_NONE) ? npc_s : '0;
            fwd_mask   <= fwd_c;
            fu_used    <= fu_c;
        end
    end

    erp_event_counter #(.W(CNT_W)) u_cnt_taken (
        .clk(clk), .rst_n(rst_n),
        .inc(kind_c == RD_BRANCH && slot_pred_taken[sel_c]),
        .count(cnt_taken_wrong)
    );

    erp_event_counter #(.W(CNT_W)) u_cnt_mem (
        .clk(clk), .rst_n(rst_n),
        .inc(kind_c == RD_MEMORD), .count(cnt_mem_order)
    );

    // R2: forwarded slots form a run of ones from slot 0.
    a_r2_mask_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
        ((fwd_mask + ISSUE_W'(1)) & fwd_mask) == '0);

    // R3: unit usage never exceeds the execute width nor the forwarded count.
    a_r3_fu_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        fu_used <= FW'(EXEC_W) && 32'(fu_used) <= $countones(fwd_mask));

    // R10: a memory-order packet carries no branch direction or PC.
    a_r10_mem_packet_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (sq_valid && !sq_mispred) |-> (!sq_taken && sq_pc == '0));

    // R12: a packet only follows a group that forwarded something.
    a_r12_packet_needs_slot: assert property (@(posedge clk) disable iff (!rst_n)
        sq_valid |-> fwd_mask != '0);

    // R11: the memory counter moves only alongside a memory-order packet.
    a_r11_mem_count_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_mem_order != $past(cnt_mem_order)) |-> (sq_valid && !sq_mispred));

    // R11: the taken counter moves only alongside a branch packet.
    a_r11_taken_count_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_taken_wrong != $past(cnt_taken_wrong)) |-> (sq_valid && sq_mispred));
endmodule

// File: tb/test_exec_redirect_sel.sv
`timescale 1ns/1ps
module test_exec_redirect_sel;
    localparam int IW = 4;
    localparam int EW = 3;
    localparam int PW = 32;
    localparam int SW = 16;
    localparam int CW = 16;
    localparam int FW = $clog2(EW + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [IW-1:0] v = '0, sq = '0, mp = '0, pt = '0, mr = '0;
    logic [IW*PW-1:0] pcs = '0, npcs = '0;
    logic [IW*SW-1:0] seqs = '0;
    logic viol = 1'b0;

    logic o_sv, o_mp, o_tk;
    logic [SW-1:0] o_seq;
    logic [PW-1:0] o_pc, o_npc;
    logic [IW-1:0] o_mask;
    logic [FW-1:0] o_fu;
    logic [CW-1:0] o_ctw, o_cmo;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    // expected state
    logic e_sv, e_mp, e_tk;
    longint e_seq, e_pc, e_npc, e_mask, e_fu;
    longint e_ctw = 0, e_cmo = 0;

    always #2.5 clk = ~clk;

    exec_redirect_sel #(.ISSUE_W(IW), .EXEC_W(EW), .PC_W(PW), .SEQ_W(SW),
                        .CNT_W(CW)) i_exec_redirect_sel (
        .clk(clk), .rst_n(rst_n), .slot_valid(v), .slot_squashed(sq),
        .slot_mispred(mp), .slot_pred_taken(pt), .slot_memref(mr),
        .slot_pc(pcs), .slot_npc(npcs), .slot_seq(seqs),
        .grp_violation(viol), .sq_valid(o_sv), .sq_mispred(o_mp),
        .sq_taken(o_tk), .sq_seq(o_seq), .sq_pc(o_pc), .sq_npc(o_npc),
        .fwd_mask(o_mask), .fu_used(o_fu), .cnt_taken_wrong(o_ctw),
        .cnt_mem_order(o_cmo)
    );

    task automatic chk(string req, string what, longint act, longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Behavioural model of one group, from the requirements.
    task automatic model();
        int used = 0;
        int hit = -1;
        bit is_br = 0;
        e_mask = 0;
        for (int i = 0; i < IW; i++) begin
            if (!v[i] || used >= EW) break;
            e_mask |= (64'd1 << i);
            if (!sq[i]) begin
                used++;
                if (hit < 0 && mp[i]) begin hit = i; is_br = 1; end
                else if (hit < 0 && viol && mr[i]) begin hit = i; is_br = 0; end
            end
        end
        e_fu = used;
        e_sv = (hit >= 0);
        e_mp = e_sv && is_br;
        e_seq = 0; e_pc = 0; e_npc = 0; e_tk = 0;
        if (hit >= 0) begin
            e_seq = seqs[hit*SW +: SW];
            e_npc = npcs[hit*PW +: PW];
            if (is_br) begin
                e_pc = pcs[hit*PW +: PW];
                e_tk = (npcs[hit*PW +: PW] != pcs[hit*PW +: PW] + 32'd4);
                if (pt[hit]) e_ctw++;
            end else e_cmo++;
        end
    endtask

    task automatic compare(string req);
        chk(req, "sq_valid (R12)", o_sv, e_sv);
        chk(req, "sq_mispred (R8)", o_mp, e_mp);
        chk(req, "sq_taken (R9)", o_tk, e_tk);
        chk(req, "sq_seq (R8)", o_seq, e_seq);
        chk(req, "sq_pc (R10)", o_pc, e_pc);
        chk(req, "sq_npc (R8)", o_npc, e_npc);
        chk(req, "fwd_mask (R2)", o_mask, e_mask);
        chk(req, "fu_used (R3)", o_fu, e_fu);
        chk(req, "cnt_taken_wrong (R11)", o_ctw, e_ctw & 16'hFFFF);
        chk(req, "cnt_mem_order (R11)", o_cmo, e_cmo & 16'hFFFF);
    endtask

    // Fill per-slot addresses: sequential unless the slot is in redir_bits.
    task automatic fill(logic [IW-1:0] redir_bits);
        for (int i = 0; i < IW; i++) begin
            pcs[i*PW +: PW]  = 32'h1000 + 32'(i * 16);
            npcs[i*PW +: PW] = redir_bits[i] ? 32'h8000 + 32'(i * 256)
                                             : 32'h1000 + 32'(i * 16) + 32'd4;
            seqs[i*SW +: SW] = 16'(100 + i);
        end
    endtask

    // Drive at falling edge, compare one edge later at the next falling edge.
    task automatic group(string req, logic [IW-1:0] gv, logic [IW-1:0] gsq,
                         logic [IW-1:0] gmp, logic [IW-1:0] gpt,
                         logic [IW-1:0] gmr, logic gviol, logic [IW-1:0] rb);
        v = gv; sq = gsq; mp = gmp; pt = gpt; mr = gmr; viol = gviol;
        fill(rb);
        model();
        @(negedge clk);
        compare(req);
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset with busy inputs leaves all outputs clear
        v = '1; mp = '1; pt = '1; fill('1);
        repeat (3) @(negedge clk);
        e_sv = 0; e_mp = 0; e_tk = 0; e_seq = 0; e_pc = 0; e_npc = 0;
        e_mask = 0; e_fu = 0;
        compare("R1");
        rst_n = 1'b1;

        // R2: empty group and a gap after slot 0
        group("R2", 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 1'b0, 4'b0000);
        group("R2", 4'b1101, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 1'b0, 4'b0000);
        // R3: limit of 3 units stops before slot 3 even though it is squashed
        group("R3", 4'b1111, 4'b1000, 4'b1000, 4'b0000, 4'b0000, 1'b0, 4'b1000);
        // R3: squashed slot lets all four through
        group("R3", 4'b1111, 4'b0010, 4'b0000, 4'b0000, 4'b0000, 1'b0, 4'b0000);
        // R4: squashed mispredict raises nothing
        group("R4", 4'b0011, 4'b0001, 4'b0001, 4'b0001, 4'b0000, 1'b0, 4'b0001);
        // R5: two mispredicts, first wins
        group("R5", 4'b0111, 4'b0000, 4'b0110, 4'b0100, 4'b0000, 1'b0, 4'b0110);
        // R6: same slot mispredicts and is a violating memory ref
        group("R6", 4'b0011, 4'b0000, 4'b0010, 4'b0010, 4'b0010, 1'b1, 4'b0010);
        // R7: violation with no memory reference is ignored
        group("R7", 4'b0111, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 1'b1, 4'b0000);
        // R7/R10: violation lands on the memory slot
        group("R10", 4'b0111, 4'b0000, 4'b0000, 4'b0000, 4'b0100, 1'b1, 4'b0000);
        // R9: mispredict whose next-PC is sequential gives taken = 0
        group("R9", 4'b0001, 4'b0000, 4'b0001, 4'b0001, 4'b0000, 1'b0, 4'b0000);
        // R12: quiet group after a redirect drops sq_valid
        group("R12", 4'b0001, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 1'b0, 4'b0000);

        // R5..R11: random groups
        for (int n = 0; n < 400; n++) begin
            for (int i = 0; i < IW; i++) begin
                v[i]  = ($urandom % 8) != 0;
                sq[i] = ($urandom % 4) == 0;
                mp[i] = ($urandom % 4) == 0;
                pt[i] = $urandom % 2;
                mr[i] = ($urandom % 5) < 2;
                pcs[i*PW +: PW]  = {$urandom} & 32'hFFFF_FFFC;
                npcs[i*PW +: PW] = ($urandom % 2) ? pcs[i*PW +: PW] + 32'd4
                                                  : {$urandom} & 32'hFFFF_FFFC;
                seqs[i*SW +: SW] = 16'($urandom);
            end
            viol = ($urandom % 3) == 0;
            model();
            @(negedge clk);
            compare("R5 R11 random");
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule